// File: doc/BRIEF.md
# Serial Bit Error Injector

The block sits in the transmit path of a bit-error-rate test generator. It passes a serial bit stream through with one register of delay and inverts chosen bits so that the far-end checker sees a known error pattern. A bit counts only in a cycle where the bit-valid strobe is high. Cycles with the strobe low are neither counted nor altered.

Two insertion sources can be active at once. The periodic source inverts one valid bit out of every 10^n, where n is a three-bit code in an 8-bit control byte. The one-shot source inverts a single bit on request. The request comes from a rising edge of either a control-byte bit or an external pin, and a select bit in the control byte picks which one. The external pin may change at any time because it is synchronised into the clock domain first. Each inversion also raises a one-cycle marker on an output beside the data.

Top module: `bit_err_injector`

## Requirements
- R1: After synchronous reset the control byte is 0x00, `dout`, `dout_vld` and `err_ins` are 0, and no bit is inverted until the control byte is written.
- R2: `dout_vld` and `dout` equal `din_vld` and `din` of the previous cycle, except that `dout` is inverted in exactly the cycles where `err_ins` is 1. `err_ins` is only ever 1 together with `dout_vld`.
- R3: Control byte bits [5:3] hold the rate code n. Code 0 disables periodic insertion. Code 1 to 7 inverts exactly one valid bit in every 10^n. When the code is written while periodic insertion is idle, counting restarts with the valid bits after the write cycle, and the 10^n-th of them is inverted.
- R4: A rate code written while periodic insertion is running takes effect only after the next inversion under the old code. The old spacing is kept up to that inversion, and the new spacing applies from there on.
- R5: Cycles with `din_vld` low do not advance the rate count and are never inverted.
- R6: With bit 2 (single enable) at 1 and bit 0 (pin select) at 0, a 0-to-1 change of bit 1 (software request) inverts the next valid bit. Writing bit 1 as 1 again without an intervening 0 inserts nothing more.
- R7: Any number of request edges between two valid bits yields one inversion only.
- R8: With bit 0 at 1, a rising edge on `man_ins` (after a two-flop synchroniser) inverts the next valid bit, and bit 1 has no effect. A change of bit 0 while the newly selected source is high counts as such an edge.
- R9: With bit 2 at 0, request edges from either source insert no error.
- R10: A one-shot request and a periodic inversion that fall on the same valid bit produce a single inversion, and the one-shot request is then consumed.
- R11: Bits [7:6] of the control byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte value |
| man_ins | input | 1 | Asynchronous external insert request |
| din | input | 1 | Serial data in |
| din_vld | input | 1 | Bit-valid strobe for din |
| dout | output | 1 | Serial data out, possibly inverted |
| dout_vld | output | 1 | Bit-valid strobe for dout |
| err_ins | output | 1 | One-cycle marker of an inverted bit |

## Verification
Some properties are checked on every cycle:
- the output is the delayed input with inversions only where the marker is raised;
- every marker traces back to a periodic hit or a pending one-shot request;
- idle cycles are never touched;
- the active rate code only changes at a periodic hit;
- a one-shot request is only armed while enabled;
- a coincident request and hit give one marker.

The exact spacing of periodic errors is shown only by the bench's scenarios, which measure gaps in valid bits across a deferred rate change. The same holds for collapsing several request edges into one error, ignoring the register request in pin mode, and the synchroniser delay on the pin.

// File: rtl/bei_pkg.sv
package bei_pkg;

    localparam int CODE_W = 3;

    typedef struct packed {
        logic [1:0]        spare;
        logic [CODE_W-1:0] rate;
        logic              sgl_en;
        logic              sw_req;
        logic              pin_sel;
    } ctl_t;

    // number of valid bits per periodic error for a rate code
    function automatic int unsigned decade(input logic [CODE_W-1:0] code);
        int unsigned v;
        v = 1;
        for (int i = 0; i < (1 << CODE_W) - 1; i++) begin
            if (i < int'(code)) v = v * 10;
        end
        return v;
    endfunction

endpackage

// File: rtl/bei_single.sv
module bei_single
    import bei_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_we,
    input  ctl_t cfg_wdata,
    input  logic man_ins,
    input  logic bit_vld,
    output ctl_t ctl,
    output logic pend
);
    localparam int SMSB = SYNC_STAGES - 1;

    logic [SMSB:0] sync_q;
    logic          src, src_q, rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            sync_q <= '0;
            src_q  <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (cfg_we) ctl <= cfg_wdata;
            sync_q <= {sync_q[SMSB-1:0], man_ins};
            src_q  <= src;
            if (rise && ctl.sgl_en) pend <= 1'b1;
            else if (bit_vld)       pend <= 1'b0;
        end
    end

    always_comb begin
        src  = ctl.pin_sel ? sync_q[SMSB] : ctl.sw_req;
        rise = src && !src_q;
    end

endmodule

// File: rtl/bei_rate.sv
module bei_rate
    import bei_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              bit_vld,
    output logic              hit,
    output logic [CODE_W-1:0] act_code
);
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last;
    logic [CODE_W-1:0] nxt_code;
    logic              nxt_valid;
    logic              running;

    always_comb begin
        running = (act_code != '0);
        last    = CNT_W'(decade(act_code) - 1);
        hit     = bit_vld && running && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_code  <= '0;
            nxt_code  <= '0;
            nxt_valid <= 1'b0;
            cnt       <= '0;
        end else if (hit) begin
            cnt       <= '0;
            nxt_valid <= 1'b0;
            if (wr)             act_code <= wr_code;
            else if (nxt_valid) act_code <= nxt_code;
        end else if (wr && !running) begin
            act_code <= wr_code;
            cnt      <= '0;
        end else begin
            if (wr) begin
                nxt_code  <= wr_code;
                nxt_valid <= 1'b1;
            end
            if (bit_vld && running) cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bit_err_injector.sv
module bit_err_injector
    import bei_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       man_ins,
    input  logic       din,
    input  logic       din_vld,
    output logic       dout,
    output logic       dout_vld,
    output logic       err_ins
);
    ctl_t              ctl;
    logic              pend;
    logic              hit;
    logic [CODE_W-1:0] act_code;
    logic              flip;
    logic              sgl_en;

    bei_single #(.SYNC_STAGES(SYNC_STAGES)) u_single (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_wdata(ctl_t'(cfg_wdata)),
        .man_ins  (man_ins),
        .bit_vld  (din_vld),
        .ctl      (ctl),
        .pend     (pend)
    );

    bei_rate #(.CNT_W(CNT_W)) u_rate (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_we),
        .wr_code (cfg_wdata[5:3]),
        .bit_vld (din_vld),
        .hit     (hit),
        .act_code(act_code)
    );

    always_comb begin
        flip   = din_vld && (hit || pend);
        sgl_en = ctl.sgl_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout     <= 1'b0;
            dout_vld <= 1'b0;
            err_ins  <= 1'b0;
        end else begin
            dout     <= din ^ flip;
            dout_vld <= din_vld;
            err_ins  <= flip;
        end
    end

endmodule

// File: rtl/bit_err_injector_chk.sv
module bit_err_injector_chk
    import bei_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              din,
    input logic              din_vld,
    input logic              dout,
    input logic              dout_vld,
    input logic              err_ins,
    input logic              hit,
    input logic              pend,
    input logic              sgl_en,
    input logic [CODE_W-1:0] act_code
);
    logic seen;
    always_ff @(posedge clk) seen <= !rst;

    assert_marker_vld_R2: assert property (@(posedge clk) disable iff (rst)
        err_ins |-> dout_vld);

    assert_data_path_R2: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> (dout == ($past(din) ^ err_ins)));

    assert_vld_follow_R5: assert property (@(posedge clk) disable iff (rst)
        seen |-> (dout_vld == $past(din_vld)));

    assert_idle_untouched_R5: assert property (@(posedge clk) disable iff (rst)
        !din_vld |=> !err_ins);

    assert_marker_cause_R3: assert property (@(posedge clk) disable iff (rst)
        (seen && err_ins) |-> ($past(hit) || $past(pend)));

    assert_code_defer_R4: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(act_code) != '0 && !$past(hit)) |-> (act_code == $past(act_code)));

    assert_arm_enabled_R9: assert property (@(posedge clk) disable iff (rst)
        (seen && $rose(pend)) |-> $past(sgl_en));

    assert_single_flip_R10: assert property (@(posedge clk) disable iff (rst)
        (hit && pend && din_vld) |=> err_ins);

endmodule

bind bit_err_injector bit_err_injector_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .din_vld (din_vld),
    .dout    (dout),
    .dout_vld(dout_vld),
    .err_ins (err_ins),
    .hit     (hit),
    .pend    (pend),
    .sgl_en  (sgl_en),
    .act_code(act_code)
);

// File: tb/bit_err_injector_tb.sv
module bit_err_injector_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       man_ins = 1'b0;
    logic       din = 1'b0;
    logic       din_vld = 1'b0;
    logic       dout, dout_vld, err_ins;

    int n_chk = 0;
    int n_fail = 0;
    int errcnt = 0;
    int cyc = 0;
    int stamp [0:15];
    int nst = 0;

    always #2 clk = ~clk;

    bit_err_injector u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .man_ins(man_ins), .din(din), .din_vld(din_vld),
        .dout(dout), .dout_vld(dout_vld), .err_ins(err_ins)
    );

    function automatic int unsigned spacing(input logic [2:0] n);
        int unsigned v;
        v = 1;
        for (int i = 0; i < int'(n); i++) v = v * 10;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // reference model built from the requirements
    logic [7:0] m_ctl;
    logic       m_s1, m_s2, m_srcq, m_pend, m_nv;
    logic [2:0] m_act, m_nxt;
    int unsigned m_cnt;
    logic       e_dout, e_vld, e_err;
    logic       t_src, t_rise, t_hit, t_flip;

    always @(posedge clk) begin
        if (rst) begin
            m_ctl = 0; m_s1 = 0; m_s2 = 0; m_srcq = 0; m_pend = 0; m_nv = 0;
            m_act = 0; m_nxt = 0; m_cnt = 0; e_dout = 0; e_vld = 0; e_err = 0;
        end else begin
            t_src  = m_ctl[0] ? m_s2 : m_ctl[1];
            t_rise = t_src && !m_srcq;
            t_hit  = din_vld && m_act != 0 && m_cnt == spacing(m_act) - 1;
            t_flip = din_vld && (t_hit || m_pend);
            e_dout = din ^ t_flip;
            e_vld  = din_vld;
            e_err  = t_flip;
            if (t_rise && m_ctl[2]) m_pend = 1;
            else if (din_vld) m_pend = 0;
            if (t_hit) begin
                m_cnt = 0;
                if (cfg_we) m_act = cfg_wdata[5:3];
                else if (m_nv) m_act = m_nxt;
                m_nv = 0;
            end else if (cfg_we && m_act == 0) begin
                m_act = cfg_wdata[5:3];
                m_cnt = 0;
            end else begin
                if (cfg_we) begin m_nxt = cfg_wdata[5:3]; m_nv = 1; end
                if (din_vld && m_act != 0) m_cnt = m_cnt + 1;
            end
            m_srcq = t_src;
            m_s2 = m_s1;
            m_s1 = man_ins;
            if (cfg_we) m_ctl = cfg_wdata;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk(dout_vld == e_vld && err_ins == e_err && (!e_vld || dout == e_dout),
                "R2 stream", {dout_vld, err_ins, dout}, {e_vld, e_err, e_dout});
            if (err_ins) begin
                errcnt++;
                if (nst < 16) stamp[nst] = cyc;
                nst++;
            end
        end
    end

    task automatic step(input logic v);
        din_vld = v;
        din = 1'($urandom);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b, input logic v);
        cfg_we = 1'b1;
        cfg_wdata = b;
        step(v);
    endtask

    task automatic steps(input int n, input logic v);
        for (int i = 0; i < n; i++) step(v);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        man_ins = 1'b0;
        steps(3, 1'b0);
        rst = 1'b0;
        step(1'b0);
        #2;
        errcnt = 0;
        nst = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        // R1: reset state
        rst = 1'b1;
        steps(3, 1'b1);
        #2;
        chk(dout == 0 && dout_vld == 0 && err_ins == 0, "R1 reset outputs",
            {dout, dout_vld, err_ins}, 0);
        do_reset();
        steps(30, 1'b1); steps(2, 1'b0);
        chk(errcnt == 0, "R1 no errors after reset", errcnt, 0);

        // R3: code 1 and code 2 spacing
        do_reset();
        wr(8'h08, 1'b0);
        steps(100, 1'b1); steps(2, 1'b0);
        chk(errcnt == 10, "R3 code1 count", errcnt, 10);
        do_reset();
        wr(8'h10, 1'b0);
        steps(1000, 1'b1); steps(2, 1'b0);
        chk(errcnt == 10, "R3 code2 count", errcnt, 10);

        // R5: gaps in the strobe are not counted
        do_reset();
        wr(8'h08, 1'b0);
        for (int i = 0; i < 100; i++) begin step(1'b1); step(1'b0); end
        steps(2, 1'b0);
        chk(errcnt == 10, "R5 sparse valid count", errcnt, 10);

        // R4: deferred rate change
        do_reset();
        wr(8'h08, 1'b0);
        while (errcnt == 0) step(1'b1);
        wr(8'h10, 1'b1);
        steps(250, 1'b1); steps(2, 1'b0);
        chk(stamp[1] - stamp[0] == 10, "R4 old spacing kept", stamp[1] - stamp[0], 10);
        chk(stamp[2] - stamp[1] == 100, "R4 new spacing after", stamp[2] - stamp[1], 100);

        // R6: register request edge
        do_reset();
        wr(8'h04, 1'b1); wr(8'h06, 1'b1); steps(5, 1'b1);
        wr(8'h06, 1'b1); steps(5, 1'b1);
        chk(errcnt == 1, "R6 level does not repeat", errcnt, 1);
        wr(8'h04, 1'b1); wr(8'h06, 1'b1); steps(5, 1'b1);
        chk(errcnt == 2, "R6 second edge", errcnt, 2);

        // R7: many edges without a valid bit
        do_reset();
        wr(8'h06, 1'b0); wr(8'h04, 1'b0); wr(8'h06, 1'b0); wr(8'h04, 1'b0); wr(8'h06, 1'b0);
        steps(3, 1'b0); steps(5, 1'b1); steps(2, 1'b0);
        chk(errcnt == 1, "R7 collapsed edges", errcnt, 1);

        // R8: pin mode
        do_reset();
        wr(8'h05, 1'b1);
        man_ins = 1'b1; steps(6, 1'b1); man_ins = 1'b0; steps(4, 1'b1);
        chk(errcnt == 1, "R8 pin edge", errcnt, 1);
        wr(8'h07, 1'b1); wr(8'h05, 1'b1); wr(8'h07, 1'b1); steps(5, 1'b1);
        chk(errcnt == 1, "R8 register bit ignored", errcnt, 1);

        // R9: single insertion disabled
        do_reset();
        wr(8'h02, 1'b1); wr(8'h00, 1'b1); wr(8'h02, 1'b1);
        wr(8'h01, 1'b1); man_ins = 1'b1; steps(6, 1'b1); man_ins = 1'b0;
        steps(6, 1'b1); steps(2, 1'b0);
        chk(errcnt == 0, "R9 disabled", errcnt, 0);

        // R10: coincident sources
        do_reset();
        wr(8'h0C, 1'b0);
        steps(9, 1'b1); step(1'b0);
        wr(8'h0E, 1'b0); steps(3, 1'b0);
        step(1'b1); steps(2, 1'b0);
        chk(errcnt == 1, "R10 one inversion", errcnt, 1);
        steps(5, 1'b1); steps(2, 1'b0);
        chk(errcnt == 1, "R10 request consumed", errcnt, 1);

        // R11: spare bits
        do_reset();
        wr(8'hC0, 1'b0);
        steps(50, 1'b1); steps(2, 1'b0);
        chk(errcnt == 0, "R11 spare bits", errcnt, 0);

        // random traffic against the model (R2 per cycle)
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(99) < 10) man_ins = ~man_ins;
            if ($urandom_range(99) < 4)
                wr({2'($urandom), 3'($urandom_range(2)), 3'($urandom)}, 1'($urandom_range(99) < 75));
            else
                step(1'($urandom_range(99) < 75));
        end
        steps(3, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule